// File: doc/BRIEF.md
# Power Partition Gate Controller

This controller switches up to a parameterised number of power partitions (at most 32) on and off. It also manages the isolation clamp that holds each partition's outputs while the partition is unpowered. Software drives it through a small word-addressed register file. A power change is made by toggling: a command names one partition and inverts its power request. The switch then reports that it has settled on a per-partition acknowledge input. Only after that acknowledge does the readable power status follow the request. One command may be in flight at a time.

Clamps are released by writing a mask, one bit per partition. The bit positions of the video-decode partition (index 3) and the PCIe partition (index 4) are exchanged in this mask. A clamp can only be released on a partition whose power request is on. Turning a partition off sets its clamp again at once. A build option gives the 3D partition (index 1) its own clamp register. With that option the 3D partition's mask bit is ignored.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset every power request is 0, the status register reads 0, every clamp is set (clamp register reads all partition bits 1), the separate 3D clamp register reads 1, `cmd_err` and `busy` are 0, and the command register reads 0.
- R2: A write to offset 0x030 with bit 8 set and an index in bits 4:0 below NPART, while not busy, inverts that partition's power request at the next clock edge and raises `busy`.
- R3: A write to offset 0x030 with bit 8 clear changes nothing.
- R4: A command with bit 8 set whose index is NPART or above changes no power request and sets `cmd_err`, which then stays 1 until reset.
- R5: While `busy` is 1, further valid commands are ignored: no power request changes and `cmd_err` is not set by them.
- R6: While busy, the clock edge at which `pwr_ack` is high for the pending partition copies that partition's request into status register 0x038 (bit N is 1 when partition N is powered) and clears `busy`. Acknowledges of other partitions have no effect, and status never changes otherwise.
- R7: A write to clamp register 0x034 releases the clamp of each partition p whose power request is on and whose mask bit is set, where partition 3 uses mask bit 4 and partition 4 uses mask bit 3 and every other partition uses bit p. Reading 0x034 returns the clamp lines.
- R8: With the separate 3D clamp built in (GPU_SEP=1), mask bit 1 of 0x034 has no effect. A write to offset 0x2D4 with bit 0 equal to 1 sets the 3D clamp. A write with bit 0 equal to 0 releases it if partition 1 is powered on. Bit 0 of 0x2D4 reads the 3D clamp.
- R9: An accepted command that turns a partition off sets that partition's clamp at the same edge as its request falls. For partition 1 this includes the 0x2D4 register.
- R10: Reading 0x030 gives `busy` in bit 8 and the last accepted index in bits 4:0. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwr_ack | input | NPART | Per-partition switch-settled acknowledge |
| pwr_en | output | NPART | Per-partition power request |
| clamp_on | output | NPART | Per-partition isolation clamp, 1 = clamped |
| cmd_err | output | 1 | Sticky flag for a command naming an absent partition |
| busy | output | 1 | A power toggle awaits its acknowledge |

## Verification
The assertions assume that `pwr_ack` matters only for the pending partition. They also assume that a write and a read never both need the bus in one cycle, because reads are taken with `bus_wr` low. The stimulus keeps to this by driving each write for exactly one cycle between negative edges. Acknowledge pulses are either aimed at the pending index or spread at random over all bits, so that stray acknowledges are exercised too. Random commands draw indices over the full 5-bit field, which covers out-of-range and busy-time commands alongside the directed corner cases.

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
  parameter int NPART    = 24,
  parameter int IDXW     = 5,
  parameter bit GPU_SEP  = 1'b1,
  parameter int IDX_GPU  = 1,
  parameter int IDX_VDEC = 3,
  parameter int IDX_PCIE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPART-1:0] pwr_ack,
  output logic [NPART-1:0] pwr_en,
  output logic [NPART-1:0] clamp_on,
  output logic             cmd_err,
  output logic             busy
);
  localparam logic [11:0] A_TOG  = 12'h030;
  localparam logic [11:0] A_CLR  = 12'h034;
  localparam logic [11:0] A_STAT = 12'h038;
  localparam logic [11:0] A_GPU  = 12'h2D4;
  localparam int          START  = 8;

  logic [NPART-1:0] en_q, stat_q, clamp_q, rel;
  logic [IDXW-1:0]  idx_q;
  logic             busy_q, err_q;

  wire [IDXW-1:0] widx     = bus_wdata[IDXW-1:0];
  wire            wr_tog   = bus_wr && bus_addr == A_TOG && bus_wdata[START];
  wire            in_range = 32'(widx) < NPART;
  wire            accept   = wr_tog && in_range && !busy_q;
  wire            done     = busy_q && pwr_ack[idx_q];
  wire            wr_clr   = bus_wr && bus_addr == A_CLR;
  wire            wr_gpu   = GPU_SEP && bus_wr && bus_addr == A_GPU;

  logic unused_w;
  assign unused_w = ^bus_wdata;

  always_comb begin
    for (int p = 0; p < NPART; p++) begin
      int s;
      s = (p == IDX_VDEC) ? IDX_PCIE : (p == IDX_PCIE) ? IDX_VDEC : p;
      rel[p] = wr_clr && bus_wdata[s] && en_q[p] && !(GPU_SEP && p == IDX_GPU);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      stat_q  <= '0;
      clamp_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_tog && !in_range) err_q <= 1'b1;
      if (accept) begin
        en_q[widx] <= !en_q[widx];
        idx_q      <= widx;
        busy_q     <= 1'b1;
      end else if (done) begin
        stat_q[idx_q] <= en_q[idx_q];
        busy_q        <= 1'b0;
      end
      for (int p = 0; p < NPART; p++) begin
        if (accept && 32'(widx) == p && en_q[p]) clamp_q[p] <= 1'b1;
        else if (rel[p]) clamp_q[p] <= 1'b0;
        else if (wr_gpu && p == IDX_GPU) begin
          if (bus_wdata[0]) clamp_q[p] <= 1'b1;
          else if (en_q[p]) clamp_q[p] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TOG: begin
        bus_rdata[START]     = busy_q;
        bus_rdata[IDXW-1:0]  = idx_q;
      end
      A_CLR:  bus_rdata[NPART-1:0] = clamp_q;
      A_STAT: bus_rdata[NPART-1:0] = stat_q;
      A_GPU:  bus_rdata[0] = GPU_SEP ? clamp_q[IDX_GPU] : 1'b0;
      default: bus_rdata = '0;
    endcase
  end

  assign pwr_en   = en_q;
  assign clamp_on = clamp_q;
  assign cmd_err  = err_q;
  assign busy     = busy_q;
endmodule

module pgate_ctrl_chk #(
  parameter int NPART = 24,
  parameter int IDXW  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPART-1:0] en,
  input logic [NPART-1:0] clamp,
  input logic [NPART-1:0] stat,
  input logic [NPART-1:0] ack,
  input logic [IDXW-1:0]  idx,
  input logic             err,
  input logic             busy
);
  a_r2_one_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en ^ $past(en)) <= 1);
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(en));
  a_r6_stat_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat) |-> ($past(busy) && $past(ack[idx])));
  a_r6_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> stat == en);
  a_r9_off_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (~en & ~clamp) == '0);
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);
endmodule

bind pgate_ctrl pgate_ctrl_chk #(.NPART(NPART), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(pwr_en), .clamp(clamp_on), .stat(stat_q),
  .ack(pwr_ack), .idx(idx_q), .err(cmd_err), .busy(busy)
);

// File: tb/pgate_ctrl_bench.sv
module pgate_ctrl_bench;
  localparam int N = 24;

  logic          clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [N-1:0]  pwr_ack = '0, pwr_en, clamp_on;
  logic          cmd_err, busy;

  pgate_ctrl #(.NPART(N)) u_pgate_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_ack(pwr_ack),
    .pwr_en(pwr_en), .clamp_on(clamp_on), .cmd_err(cmd_err), .busy(busy)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  logic [N-1:0] m_en = '0, m_stat = '0, m_clamp = '1;
  logic         m_err = 0, m_busy = 0;
  logic [4:0]   m_idx = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic int swp(input int j);
    return (j == 3) ? 4 : (j == 4) ? 3 : j;
  endfunction

  task automatic model(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [N-1:0] ack);
    logic [N-1:0] en0;
    logic b0;
    en0 = m_en;
    b0  = m_busy;
    if (wr && a == 12'h030 && d[8]) begin
      if (int'(d[4:0]) >= N) m_err = 1;
      else if (!b0) begin
        if (en0[d[4:0]]) m_clamp[d[4:0]] = 1;
        m_en[d[4:0]] = ~en0[d[4:0]];
        m_idx  = d[4:0];
        m_busy = 1;
      end
    end
    if (b0 && ack[m_idx]) begin
      m_stat[m_idx] = m_en[m_idx];
      m_busy = 0;
    end
    if (wr && a == 12'h034)
      for (int j = 0; j < N; j++)
        if (d[j] && swp(j) != 1 && en0[swp(j)]) m_clamp[swp(j)] = 0;
    if (wr && a == 12'h2D4) begin
      if (d[0]) m_clamp[1] = 1;
      else if (en0[1]) m_clamp[1] = 0;
    end
  endtask

  task automatic cyc(input string tag, input logic wr, input logic [11:0] a,
                     input logic [31:0] d, input logic [N-1:0] ack);
    logic [31:0] v;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; pwr_ack = ack;
    model(wr, a, d, ack);
    @(negedge clk);
    bus_wr = 0; pwr_ack = '0;
    chk({tag, " pwr_en"}, 32'(pwr_en), 32'(m_en));
    chk({tag, " clamp"}, 32'(clamp_on), 32'(m_clamp));
    chk({tag, " err"}, 32'(cmd_err), 32'(m_err));
    chk({tag, " busy"}, 32'(busy), 32'(m_busy));
    rd(12'h038, v); chk({tag, " status"}, v, 32'(m_stat));
    rd(12'h2D4, v); chk({tag, " gpu reg"}, v, 32'(m_clamp[1]));
    rd(12'h030, v); chk({tag, " cmd reg"}, v, {23'b0, m_busy, 3'b0, m_idx});
  endtask

  task automatic tog(input string tag, input int idx, input bit start);
    cyc(tag, 1, 12'h030, (32'(start) << 8) | 32'(idx), '0);
  endtask

  task automatic ackp(input string tag, input int idx);
    cyc(tag, 0, 12'h000, 0, N'(1) << idx);
  endtask

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_en", 32'(pwr_en), 0);
    chk("R1 clamp", 32'(clamp_on), 32'(N'('1)));
    chk("R1 err", 32'(cmd_err), 0);
    chk("R1 busy", 32'(busy), 0);
    rd(12'h038, v); chk("R1 status", v, 0);
    rd(12'h034, v); chk("R1 clamp reg", v, 32'(N'('1)));
    rd(12'h2D4, v); chk("R1 gpu reg", v, 1);
    rd(12'h030, v); chk("R1 cmd reg", v, 0);
    // R3 start bit clear
    tog("R3", 4, 0);
    // R2 toggle on partition 4
    tog("R2", 4, 1);
    // R5 command while busy ignored
    tog("R5", 7, 1);
    // R6 wrong ack ignored, then right ack
    ackp("R6 stray", 7);
    ackp("R6", 4);
    // R7 release partition 4 through mask bit 3; partition 3 off stays clamped
    cyc("R7", 1, 12'h034, 32'h8, '0);
    rd(12'h034, v); chk("R7 clamp reg", v, 32'(m_clamp));
    tog("R7 on3", 3, 1); ackp("R7 ack3", 3);
    cyc("R7 bit4", 1, 12'h034, 32'h10, '0);
    // R8 partition 1: mask bit ignored, own register works
    tog("R8 on1", 1, 1); ackp("R8 ack1", 1);
    cyc("R8 mask", 1, 12'h034, 32'h2, '0);
    cyc("R8 rel", 1, 12'h2D4, 32'h0, '0);
    cyc("R8 set", 1, 12'h2D4, 32'h1, '0);
    cyc("R8 rel2", 1, 12'h2D4, 32'h0, '0);
    // R9 off sets clamp
    tog("R9 off1", 1, 1); ackp("R9 ack1", 1);
    tog("R9 off4", 4, 1); ackp("R9 ack4", 4);
    // R4 out of range
    tog("R4 idx24", 24, 1);
    tog("R4 idx31", 31, 1);
    tog("R4 sticky", 2, 1); ackp("R4 ack2", 2);
    // R10 unmapped
    rd(12'h03C, v); chk("R10 unmapped", v, 0);
    rd(12'h000, v); chk("R10 zero", v, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0, 1: tog("R2 rnd", int'($urandom % 32), ($urandom % 5) != 0);
        2: cyc("R7 rnd", 1, 12'h034, $urandom, '0);
        3: cyc("R8 rnd", 1, 12'h2D4, $urandom % 2, '0);
        4, 5: ackp("R6 rnd", int'(m_idx) < N ? int'(m_idx) : 0);
        default: cyc("R6 rndack", 0, 12'h000, 0, N'($urandom));
      endcase
    end
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule